// File: doc/BRIEF.md
# Camera Pixel Capture Front End

This block receives the byte-wide pixel bus and the frame and line timing of an external image sensor, and moves them into the system clock domain. The sensor's pixel clock has no fixed relation to the system clock. The block does not use it as a clock. It passes the pixel clock through a synchronizer together with the vertical sync and the horizontal reference, and then treats it as an ordinary data signal. A detected rising edge of the synchronized pixel clock marks the moment to take one byte. The data bus travels through a delay chain of the same depth, so that the byte taken lines up with that edge.

Each byte taken during an active line appears on `byte_o` with a one-cycle strobe. Single-cycle pulses mark the start of each frame and each line. A status flag shows when a frame is being received. An enable input, normally tied to "sensor configured", gates all of this.

A small state machine controls the enable gating. Its states are:
- OFF: not armed.
- WAIT: armed and waiting for a frame boundary.
- ACTIVE: receiving a frame.

Its transitions are:
- OFF→WAIT when enable is high.
- WAIT→OFF when enable drops.
- WAIT→ACTIVE on a vertical sync rise.
- ACTIVE→OFF on a vertical sync rise seen while enable is low.

While ACTIVE, a vertical sync rise with enable high keeps the machine in ACTIVE.

Top module: `pixcap_frontend`

## Requirements
- R1: While `sys_rst` is high, and in the cycle after it falls, `byte_stb_o`, `frame_stb_o`, `line_stb_o`, `in_frame_o` and `byte_o` are all 0.
- R2: The sensor clock, vertical sync and horizontal reference each pass through a two-stage synchronizer. The sensor clock must run at no more than one third of `sys_clk`. Each delivered byte is the value on `cam_d_i` at the corresponding sensor-clock rising edge.
- R3: While capturing and enabled, every sensor-clock rising edge with the horizontal reference high yields exactly one `byte_stb_o` pulse, one cycle wide. Bytes appear in the order they were driven.
- R4: Sensor-clock edges while the horizontal reference is low produce no byte.
- R5: `frame_stb_o` pulses for one cycle on a vertical sync rise when enable is high and the state is WAIT or ACTIVE.
- R6: `line_stb_o` pulses for one cycle on a horizontal reference rise when the state is ACTIVE and enable is high.
- R7: `in_frame_o` goes high only together with a `frame_stb_o` pulse. If enable rises in the middle of a frame, that frame produces no bytes and no pulses, and capture begins with the next frame.
- R8: While enable is low, no bytes, frame pulses or line pulses are produced. `in_frame_o` stays high after enable drops, and clears on the next vertical sync rise.
- R9: Each `line_stb_o` comes before the first byte of its line, and the number of bytes between consecutive line pulses equals the line length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous reset, active high |
| cap_enable | input | 1 | Capture enable (sensor configured) |
| cam_clk_i | input | 1 | Sensor pixel clock, asynchronous, sampled as data |
| cam_vs_i | input | 1 | Sensor vertical sync, asynchronous |
| cam_hs_i | input | 1 | Sensor horizontal reference (line active), asynchronous |
| cam_d_i | input | DATA_W | Sensor pixel data bus |
| byte_o | output | DATA_W | Last captured byte |
| byte_stb_o | output | 1 | One-cycle strobe for a new byte |
| frame_stb_o | output | 1 | One-cycle frame start pulse |
| line_stb_o | output | 1 | One-cycle line start pulse |
| in_frame_o | output | 1 | Frame reception in progress (state ACTIVE) |

## Verification
The assertions rely on two assumptions about the inputs. First, the sensor clock is at least three system cycles per period, so two byte strobes are never adjacent. Second, the vertical sync and horizontal reference never produce rising edges in consecutive cycles. The stimulus drives all sensor signals from the falling edge of a 134 ns sensor clock against a 20 ns system clock, so data is stable around every rising edge. Enable changes only during line blanking, well clear of any horizontal reference rise.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACTIVE = 2'd2
    } cap_state_e;

    // bit positions in the synchronized control vector
    localparam int CTRL_W    = 3;
    localparam int IDX_PCLK  = 0;
    localparam int IDX_VSYNC = 1;
    localparam int IDX_HREF  = 2;
endpackage

// File: rtl/pixcap_sync.sv
module pixcap_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pixcap_edge.sv
module pixcap_edge #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/pixcap_ctrl.sv
module pixcap_ctrl
    import pixcap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic vsync_rise,
    input  logic href_rise,
    output logic frame_pulse,
    output logic line_pulse,
    output logic capturing,
    output logic gate
);
    cap_state_e state, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:    if (enable) nxt = ST_WAIT;
            ST_WAIT:   begin
                if (!enable)         nxt = ST_OFF;
                else if (vsync_rise) nxt = ST_ACTIVE;
            end
            ST_ACTIVE: if (vsync_rise && !enable) nxt = ST_OFF;
            default:   nxt = ST_OFF;
        endcase
    end

    // registered boundary pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_pulse <= 1'b0;
            line_pulse  <= 1'b0;
        end else begin
            frame_pulse <= vsync_rise && enable && (state != ST_OFF);
            line_pulse  <= href_rise && enable && (state == ST_ACTIVE);
        end
    end

    assign capturing = (state == ST_ACTIVE);
    assign gate      = capturing && enable;

    // R7
    start_with_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(capturing) |-> frame_pulse);
    // R5
    frame_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |=> !frame_pulse);
    // R6
    line_single_chk: assert property (@(posedge clk) disable iff (rst)
        line_pulse |=> !line_pulse);
    // R8
    quiet_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse || line_pulse) |-> $past(enable));
    // R8
    stop_on_vsync_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(capturing) |-> $past(vsync_rise));
endmodule

// File: rtl/pixcap_frontend.sv
module pixcap_frontend
    import pixcap_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic              cap_enable,
    input  logic              cam_clk_i,
    input  logic              cam_vs_i,
    input  logic              cam_hs_i,
    input  logic [DATA_W-1:0] cam_d_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_stb_o,
    output logic              frame_stb_o,
    output logic              line_stb_o,
    output logic              in_frame_o
);
    logic [CTRL_W-1:0] ctrl_raw, ctrl_s, ctrl_rise;
    logic [DATA_W-1:0] data_s;
    logic              gate, take;

    assign ctrl_raw = {cam_hs_i, cam_vs_i, cam_clk_i};

    pixcap_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
        .clk(sys_clk), .rst(sys_rst), .d(ctrl_raw), .q(ctrl_s)
    );

    // data delayed by the same depth to line up with the detected clock edge
    pixcap_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_data_dly (
        .clk(sys_clk), .rst(sys_rst), .d(cam_d_i), .q(data_s)
    );

    pixcap_edge #(.WIDTH(CTRL_W)) u_edge (
        .clk(sys_clk), .rst(sys_rst), .lvl(ctrl_s), .rise(ctrl_rise)
    );

    pixcap_ctrl u_ctrl (
        .clk(sys_clk), .rst(sys_rst), .enable(cap_enable),
        .vsync_rise(ctrl_rise[IDX_VSYNC]), .href_rise(ctrl_rise[IDX_HREF]),
        .frame_pulse(frame_stb_o), .line_pulse(line_stb_o),
        .capturing(in_frame_o), .gate(gate)
    );

    assign take = gate && ctrl_rise[IDX_PCLK] && ctrl_s[IDX_HREF];

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            byte_stb_o <= 1'b0;
            byte_o     <= '0;
        end else begin
            byte_stb_o <= take;
            if (take) byte_o <= data_s;
        end
    end

    // R3
    byte_single_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        byte_stb_o |=> !byte_stb_o);
    // R4
    byte_in_line_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        byte_stb_o |-> $past(ctrl_s[IDX_HREF]));
    // R8
    byte_in_frame_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        byte_stb_o |-> (in_frame_o && $past(cap_enable)));
endmodule

// File: tb/pixcap_frontend_test.sv
`timescale 1ns/1ps
module pixcap_frontend_test;
    logic       sys_clk = 0, sys_rst = 1, cap_enable = 0;
    logic       cam_clk_i = 0, cam_vs_i = 0, cam_hs_i = 0;
    logic [7:0] cam_d_i = 8'h00;
    logic [7:0] byte_o;
    logic       byte_stb_o, frame_stb_o, line_stb_o, in_frame_o;

    pixcap_frontend uut (.*);

    always #10 sys_clk = ~sys_clk;     // 50 MHz
    always #67 cam_clk_i = ~cam_clk_i; // unrelated sensor clock

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    int lens[$];
    int frame_cnt, line_cnt, byte_cnt, run_cnt, orphan, wide;
    bit seen_line, prev_f, prev_l, armed;
    int exp_frames, exp_lines, exp_bytes;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(negedge sys_clk) if (!sys_rst) begin
        if (byte_stb_o) begin
            byte_cnt++; run_cnt++;
            if (!seen_line) orphan++;
            if (exp_q.size() == 0) check(0, "R4 unexpected byte", int'(byte_o), -1);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(byte_o == e, "R2 R3 byte order", int'(byte_o), int'(e));
            end
        end
        if (frame_stb_o) frame_cnt++;
        if (line_stb_o) begin
            line_cnt++;
            if (seen_line) lens.push_back(run_cnt);
            run_cnt = 0; seen_line = 1;
        end
        if ((frame_stb_o && prev_f) || (line_stb_o && prev_l)) wide++;
        prev_f = frame_stb_o; prev_l = line_stb_o;
    end

    task automatic clear_stats();
        frame_cnt = 0; line_cnt = 0; byte_cnt = 0; run_cnt = 0; orphan = 0; wide = 0;
        seen_line = 0; exp_frames = 0; exp_lines = 0; exp_bytes = 0;
        lens.delete(); exp_q.delete();
    endtask

    // one frame, driven from the falling sensor-clock edge
    task automatic drive_frame(input int lines, input int ppl, input logic [7:0] base,
                               input int flip_line, input logic flip_val);
        logic [7:0] v;
        v = base;
        @(negedge cam_clk_i);
        cam_vs_i = 1;
        armed = cap_enable;
        if (cap_enable) exp_frames++;
        repeat (3) @(negedge cam_clk_i);
        cam_vs_i = 0;
        repeat (3) @(negedge cam_clk_i);
        for (int l = 0; l < lines; l++) begin
            if (l == flip_line) cap_enable = flip_val;
            repeat (2) @(negedge cam_clk_i);
            if (armed && cap_enable) exp_lines++;
            for (int p = 0; p < ppl; p++) begin
                @(negedge cam_clk_i);
                cam_hs_i = 1; cam_d_i = v;
                if (armed && cap_enable) begin exp_q.push_back(v); exp_bytes++; end
                v = v + 8'd1;
            end
            @(negedge cam_clk_i);
            cam_hs_i = 0; cam_d_i = 8'h5A; // blanking junk must be ignored
            repeat (3) @(negedge cam_clk_i);
        end
    endtask

    task automatic frame_checks(input int ppl, input bit exp_in);
        if (seen_line) lens.push_back(run_cnt);
        check(byte_cnt == exp_bytes, "R3 R8 byte count", byte_cnt, exp_bytes);
        check(exp_q.size() == 0, "R3 bytes missing", exp_q.size(), 0);
        check(frame_cnt == exp_frames, "R5 frame pulses", frame_cnt, exp_frames);
        check(line_cnt == exp_lines, "R6 line pulses", line_cnt, exp_lines);
        check(orphan == 0, "R9 byte before line pulse", orphan, 0);
        check(wide == 0, "R5 R6 pulse width", wide, 0);
        foreach (lens[i]) check(lens[i] == ppl, "R9 bytes per line", lens[i], ppl);
        check(in_frame_o == exp_in, "R7 R8 in_frame", int'(in_frame_o), int'(exp_in));
    endtask

    // {enable, lines, bytes per line, first byte, expected bytes}
    localparam logic [39:0] VEC [4] = '{
        {8'd0, 8'd2, 8'd4, 8'h10, 8'd0},
        {8'd1, 8'd3, 8'd6, 8'h20, 8'd18},
        {8'd1, 8'd4, 8'd5, 8'hA0, 8'd20},
        {8'd1, 8'd2, 8'd8, 8'hF8, 8'd16}
    };

    bit done = 0;
    initial begin
        repeat (20 * 150000) @(posedge sys_clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_stats();
        repeat (5) @(posedge sys_clk);
        @(negedge sys_clk);
        check({byte_stb_o, frame_stb_o, line_stb_o, in_frame_o} == 4'b0, "R1 flags in reset",
              int'({byte_stb_o, frame_stb_o, line_stb_o, in_frame_o}), 0);
        sys_rst = 0;
        @(negedge sys_clk);
        check(byte_o == 8'h00 && !in_frame_o, "R1 after reset", int'(byte_o), 0);

        for (int i = 0; i < 4; i++) begin
            clear_stats();
            cap_enable = VEC[i][32];
            repeat (10) @(posedge sys_clk);
            drive_frame(int'(VEC[i][31:24]), int'(VEC[i][23:16]), VEC[i][15:8], -1, 1'b0);
            check(exp_bytes == int'(VEC[i][7:0]), "R3 vector model", exp_bytes, int'(VEC[i][7:0]));
            frame_checks(int'(VEC[i][23:16]), VEC[i][32]);
        end

        // enable drops after the first line: flag stays until next vsync
        clear_stats();
        drive_frame(3, 4, 8'h40, 1, 1'b0);
        frame_checks(4, 1'b1);
        clear_stats();
        drive_frame(2, 4, 8'h60, -1, 1'b0);
        frame_checks(4, 1'b0);

        // enable rises mid-frame: nothing until the next frame
        clear_stats();
        drive_frame(3, 4, 8'h70, 0, 1'b1);
        frame_checks(4, 1'b0);
        clear_stats();
        drive_frame(2, 3, 8'h90, -1, 1'b0);
        frame_checks(3, 1'b1);

        // reset while receiving
        @(negedge sys_clk);
        sys_rst = 1;
        repeat (3) @(negedge sys_clk);
        check(!in_frame_o && !byte_stb_o && byte_o == 8'h00, "R1 reset in frame",
              int'(in_frame_o), 0);
        sys_rst = 0;
        clear_stats();
        repeat (10) @(posedge sys_clk);
        drive_frame(2, 5, 8'hC0, -1, 1'b0);
        frame_checks(5, 1'b1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule